// File: doc/BRIEF.md
# Camera Byte-Pair Pixel Capture

This block sits directly behind an 8-bit parallel image-sensor bus. It runs on the sensor's pixel clock and takes a data byte, a line-valid level and a frame-sync level. While a line is valid, it joins each pair of successive bytes into one 16-bit RGB565 pixel. The pixel leaves the block with a one-cycle valid strobe, its column and row position, and a flag on the first pixel of each frame. A separate one-cycle marker reports the end of every captured line. All of this lets downstream filters locate each pixel without keeping their own counters.

The byte phase is tied to the line-valid level. Each line starts again from the high byte, so a line with an odd byte count cannot shift the pairing of later lines. The block stays silent after reset until it has seen one whole frame-sync pulse: first inactive, then active, then inactive again. A frame already in progress when reset is released is therefore dropped.

Parameters set the byte width, the counter widths, the polarity of the line and frame levels, and the order of the two bytes within a pixel.

Top module: `pix_pair_capture`

## Requirements
- R1: While reset is asserted and right after it is released, pix_valid, pix_sof and pix_eol are 0 and pix_data, pix_col and pix_row are 0.
- R2: With the default byte order (HIGH_FIRST=1), the first byte of a pair lands in pix_data[15:8] (R5 and upper G3) and the second byte lands in pix_data[7:0].
- R3: Bytes presented while line-valid is inactive are ignored. The pairing restarts with a high byte at every line start, so an unpaired trailing byte is dropped and does not affect the next line.
- R4: pix_valid is high for exactly one pixel-clock cycle per completed byte pair. It is never high in two consecutive cycles.
- R5: pix_eol pulses for one cycle once per captured line, after line-valid goes inactive, and never in the same cycle as pix_valid.
- R6: pix_sof is high together with pix_valid only on the first pixel delivered after a frame-sync pulse ends. That pixel has pix_col = 0.
- R7: pix_col is 0 for the first pixel of every line and rises by 1 for each following pixel of the same line.
- R8: pix_row is 0 for lines of the first line period after a frame-sync pulse ends, and rises by 1 for every line-valid period, including lines too short to form a pixel.
- R9: No pixel and no end-of-line marker is produced until a complete frame-sync pulse (inactive, active, inactive) has been seen after reset. A pulse already active when reset is released does not count.
- R10: A frame of only 4 lines produces exactly 4 end-of-line markers, and its last pixels carry pix_row = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_byte | input | 8 | Sensor data byte |
| cam_lval | input | 1 | Line-valid level (active high by default) |
| cam_fsync | input | 1 | Frame-sync level (active high by default) |
| pix_data | output | 16 | Assembled RGB565 pixel |
| pix_valid | output | 1 | One-cycle strobe for a new pixel |
| pix_sof | output | 1 | First pixel of a frame (qualified by pix_valid) |
| pix_eol | output | 1 | One-cycle end-of-line marker |
| pix_col | output | 11 | Column index of the pixel |
| pix_row | output | 10 | Row index of the pixel |

## Verification
The hardest situation to reach is reset released while a frame-sync pulse is already active, followed by lines that must be discarded. The bench holds frame-sync active through reset, drops it, sends a full set of lines, and requires that nothing comes out until a clean pulse has passed. After that, a sweep of 4-line frames grows the line lengths through odd and even byte counts, starting from a single byte. This makes every line end at both phases and pushes the first pixel of a frame onto a later row, while garbage bytes fill every blanking gap.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

   typedef enum logic [1:0] {
      ARM_WAIT_IDLE  = 2'd0,
      ARM_WAIT_PULSE = 2'd1,
      ARM_WAIT_END   = 2'd2,
      ARM_RUN        = 2'd3
   } arm_state_t;

   function automatic logic [1:0] arm_code(input arm_state_t s);
      return logic'(s == ARM_RUN) ? 2'b11 : 2'(s);
   endfunction

endpackage

// File: rtl/pxc_in_stage.sv
module pxc_in_stage #(
   parameter int BYTE_W           = 8,
   parameter bit LVAL_ACTIVE_LOW  = 1'b0,
   parameter bit FSYNC_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cam_byte,
   input  logic              cam_lval,
   input  logic              cam_fsync,
   output logic [BYTE_W-1:0] byte_q,
   output logic              lval_q,
   output logic              fsync_q
);

   logic lval_norm;
   logic fsync_norm;

   generate
      if (LVAL_ACTIVE_LOW) begin : g_lval_low
         assign lval_norm = ~cam_lval;
      end else begin : g_lval_high
         assign lval_norm = cam_lval;
      end
      if (FSYNC_ACTIVE_LOW) begin : g_fsync_low
         assign fsync_norm = ~cam_fsync;
      end else begin : g_fsync_high
         assign fsync_norm = cam_fsync;
      end
   endgenerate

   // frame-sync register resets to "active" so a level already present
   // at reset release is never mistaken for an idle-to-active edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q  <= '0;
         lval_q  <= 1'b0;
         fsync_q <= 1'b1;
      end else begin
         byte_q  <= cam_byte;
         lval_q  <= lval_norm;
         fsync_q <= fsync_norm;
      end
   end

endmodule

// File: rtl/pxc_frame_arm.sv
module pxc_frame_arm
   import pxc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fsync_q,
   output logic run,
   output logic frame_start
);

   arm_state_t state, state_nx;
   logic       fsync_prev;

   always_comb begin
      state_nx    = state;
      frame_start = 1'b0;
      unique case (state)
         ARM_WAIT_IDLE:  if (!fsync_q) state_nx = ARM_WAIT_PULSE;
         ARM_WAIT_PULSE: if (fsync_q)  state_nx = ARM_WAIT_END;
         ARM_WAIT_END: begin
            if (!fsync_q) begin
               state_nx    = ARM_RUN;
               frame_start = 1'b1;
            end
         end
         ARM_RUN:        frame_start = fsync_prev & ~fsync_q;
         default:        state_nx = ARM_WAIT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ARM_WAIT_IDLE;
         fsync_prev <= 1'b1;
      end else begin
         state      <= state_nx;
         fsync_prev <= fsync_q;
      end
   end

   assign run = (arm_code(state) == 2'b11);

endmodule

// File: rtl/pxc_pair_pack.sv
module pxc_pair_pack #(
   parameter int BYTE_W     = 8,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int PIX_W     = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_q,
   input  logic              lval_q,
   input  logic              run,
   output logic              pair_done,
   output logic [PIX_W-1:0]  word
);

   logic              phase;
   logic [BYTE_W-1:0] first_byte;

   assign pair_done = run & lval_q & phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= 1'b0;
         first_byte <= '0;
      end else if (!(run && lval_q)) begin
         phase      <= 1'b0;
      end else begin
         phase <= ~phase;
         if (!phase) first_byte <= byte_q;
      end
   end

   generate
      if (HIGH_FIRST) begin : g_hi_first
         assign word = {first_byte, byte_q};
      end else begin : g_lo_first
         assign word = {byte_q, first_byte};
      end
   endgenerate

endmodule

// File: rtl/pxc_coord.sv
module pxc_coord #(
   parameter int COL_W = 11,
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lval_q,
   input  logic             run,
   input  logic             frame_start,
   input  logic             pair_done,
   output logic [COL_W-1:0] col_cnt,
   output logic [ROW_W-1:0] row_cnt,
   output logic             sof_pend,
   output logic             line_end
);

   logic lval_prev;

   assign line_end = run & lval_prev & ~lval_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lval_prev <= 1'b0;
         col_cnt   <= '0;
         row_cnt   <= '0;
         sof_pend  <= 1'b0;
      end else begin
         lval_prev <= lval_q & run;
         if (!lval_q)        col_cnt <= '0;
         else if (pair_done) col_cnt <= col_cnt + 1'b1;
         if (frame_start)    row_cnt <= '0;
         else if (line_end)  row_cnt <= row_cnt + 1'b1;
         if (frame_start)    sof_pend <= 1'b1;
         else if (pair_done) sof_pend <= 1'b0;
      end
   end

endmodule

// File: rtl/pix_pair_capture.sv
module pix_pair_capture #(
   parameter int BYTE_W           = 8,
   parameter int COL_W            = 11,
   parameter int ROW_W            = 10,
   parameter bit HIGH_FIRST       = 1'b1,
   parameter bit LVAL_ACTIVE_LOW  = 1'b0,
   parameter bit FSYNC_ACTIVE_LOW = 1'b0,
   localparam int PIX_W           = 2 * BYTE_W
) (
   input  logic              pclk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cam_byte,
   input  logic              cam_lval,
   input  logic              cam_fsync,
   output logic [PIX_W-1:0]  pix_data,
   output logic              pix_valid,
   output logic              pix_sof,
   output logic              pix_eol,
   output logic [COL_W-1:0]  pix_col,
   output logic [ROW_W-1:0]  pix_row
);

   generate
      if (BYTE_W < 1 || BYTE_W > 32) begin : g_bad_byte
         $error("pix_pair_capture: BYTE_W out of range");
      end
      if (COL_W < 1 || ROW_W < 1) begin : g_bad_cnt
         $error("pix_pair_capture: counter widths must be positive");
      end
   endgenerate

   logic [BYTE_W-1:0] byte_q;
   logic              lval_q, fsync_q;
   logic              run, frame_start;
   logic              pair_done, line_end, sof_pend;
   logic [PIX_W-1:0]  word;
   logic [COL_W-1:0]  col_cnt;
   logic [ROW_W-1:0]  row_cnt;

   pxc_in_stage #(
      .BYTE_W(BYTE_W), .LVAL_ACTIVE_LOW(LVAL_ACTIVE_LOW),
      .FSYNC_ACTIVE_LOW(FSYNC_ACTIVE_LOW)
   ) u_in (
      .clk(pclk), .rst_n(rst_n), .cam_byte(cam_byte), .cam_lval(cam_lval),
      .cam_fsync(cam_fsync), .byte_q(byte_q), .lval_q(lval_q), .fsync_q(fsync_q)
   );

   pxc_frame_arm u_arm (
      .clk(pclk), .rst_n(rst_n), .fsync_q(fsync_q), .run(run),
      .frame_start(frame_start)
   );

   pxc_pair_pack #(.BYTE_W(BYTE_W), .HIGH_FIRST(HIGH_FIRST)) u_pack (
      .clk(pclk), .rst_n(rst_n), .byte_q(byte_q), .lval_q(lval_q), .run(run),
      .pair_done(pair_done), .word(word)
   );

   pxc_coord #(.COL_W(COL_W), .ROW_W(ROW_W)) u_coord (
      .clk(pclk), .rst_n(rst_n), .lval_q(lval_q), .run(run),
      .frame_start(frame_start), .pair_done(pair_done), .col_cnt(col_cnt),
      .row_cnt(row_cnt), .sof_pend(sof_pend), .line_end(line_end)
   );

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_valid <= 1'b0;
         pix_sof   <= 1'b0;
         pix_eol   <= 1'b0;
         pix_col   <= '0;
         pix_row   <= '0;
      end else begin
         pix_valid <= pair_done;
         pix_eol   <= line_end;
         pix_sof   <= pair_done & sof_pend;
         if (pair_done) begin
            pix_data <= word;
            pix_col  <= col_cnt;
            pix_row  <= row_cnt;
         end
      end
   end

endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
   parameter int COL_W = 11,
   parameter int ROW_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid,
   input logic             pix_sof,
   input logic             pix_eol,
   input logic [COL_W-1:0] pix_col,
   input logic [ROW_W-1:0] pix_row
);

   logic [COL_W-1:0] last_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         last_col <= '0;
      else if (pix_valid) last_col <= pix_col;
   end

   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> !pix_valid);

   assert_eol_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_eol |-> !pix_valid);

   assert_eol_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_eol |=> !pix_eol);

   assert_sof_first_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_sof |-> (pix_valid && pix_col == '0));

   assert_origin_is_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_col == '0 && pix_row == '0) |-> pix_sof);

   assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_col != '0) |-> (pix_col == COL_W'(last_col + 1'b1)));

endmodule

bind pix_pair_capture pxc_checker #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pxc_checker (
   .clk(pclk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
   .pix_eol(pix_eol), .pix_col(pix_col), .pix_row(pix_row)
);

// File: tb/pix_pair_capture_bench.sv
module pix_pair_capture_bench;

   logic        pclk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cam_byte = 8'h00;
   logic        cam_lval = 1'b0;
   logic        cam_fsync = 1'b1;
   logic [15:0] pix_data;
   logic        pix_valid, pix_sof, pix_eol;
   logic [10:0] pix_col;
   logic [9:0]  pix_row;

   always #5 pclk = ~pclk;

   pix_pair_capture u_pix_pair_capture (
      .pclk(pclk), .rst_n(rst_n), .cam_byte(cam_byte), .cam_lval(cam_lval),
      .cam_fsync(cam_fsync), .pix_data(pix_data), .pix_valid(pix_valid),
      .pix_sof(pix_sof), .pix_eol(pix_eol), .pix_col(pix_col), .pix_row(pix_row)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [15:0] exp_data [0:511];
   int          exp_col  [0:511];
   int          exp_row  [0:511];
   bit          exp_sof  [0:511];
   int          exp_n    = 0;
   int          got_n    = 0;
   int          eol_n    = 0;
   int          last_row = 0;
   bit          prev_valid = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic logic [7:0] bval(input int f, input int l, input int b);
      return 8'(f * 53 + l * 29 + b * 7 + 3);
   endfunction

   // output monitor, sampled away from the rising edge
   always @(negedge pclk) begin
      if (rst_n && !done) begin
         if (pix_valid) begin
            if (got_n >= exp_n) begin
               check(1'b0, "R9 pixel before arming or extra pixel", got_n, exp_n);
            end else begin
               check(pix_data == exp_data[got_n], "R2 pixel data", pix_data, exp_data[got_n]);
               check(int'(pix_col) == exp_col[got_n], "R7 column", pix_col, exp_col[got_n]);
               check(int'(pix_row) == exp_row[got_n], "R8 row", pix_row, exp_row[got_n]);
               check(pix_sof == exp_sof[got_n], "R6 start of frame", pix_sof, exp_sof[got_n]);
            end
            last_row = int'(pix_row);
            got_n++;
         end
         if (pix_valid && prev_valid) check(1'b0, "R4 back-to-back valid", 1, 0);
         if (pix_eol && pix_valid)    check(1'b0, "R5 eol with valid", 1, 0);
         if (pix_eol) eol_n++;
         prev_valid = pix_valid;
      end
   end

   task automatic send_line(input int f, input int l, input int nbytes, input bit cap,
                            inout bit first);
      for (int b = 0; b < nbytes; b++) begin
         @(negedge pclk);
         cam_lval = 1'b1;
         cam_byte = bval(f, l, b);
         if (cap && (b % 2 == 1)) begin
            exp_data[exp_n] = {bval(f, l, b - 1), bval(f, l, b)};
            exp_col[exp_n]  = b / 2;
            exp_row[exp_n]  = l;
            exp_sof[exp_n]  = first;
            first = 1'b0;
            exp_n++;
         end
      end
      // blanking gap with junk on the bus (R3)
      for (int g = 0; g < 3; g++) begin
         @(negedge pclk);
         cam_lval = 1'b0;
         cam_byte = 8'(8'hA5 ^ (g * 8'h3C) ^ l);
      end
   endtask

   task automatic send_frame(input int f, input int base, input bit pulse, input bit cap);
      bit first = 1'b1;
      int eol0;
      if (pulse) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge pclk);
            cam_fsync = 1'b1;
         end
      end
      @(negedge pclk);
      cam_fsync = 1'b0;
      repeat (2) @(negedge pclk);
      eol0 = eol_n;
      for (int l = 0; l < 4; l++) send_line(f, l, base + l, cap, first);
      repeat (4) @(negedge pclk);
      check(eol_n - eol0 == (cap ? 4 : 0), cap ? "R10 eol count of 4-line frame"
                                               : "R9 eol before arming",
            eol_n - eol0, cap ? 4 : 0);
      check(got_n == exp_n, "R3 pixel count per frame", got_n, exp_n);
      if (cap && base + 3 >= 2)
         check(last_row == 3, "R10 last row index", last_row, 3);
   endtask

   initial begin
      // frame-sync held active through reset: partial pulse (R9)
      repeat (3) @(negedge pclk);
      check(pix_valid == 1'b0 && pix_sof == 1'b0 && pix_eol == 1'b0,
            "R1 strobes in reset", {pix_valid, pix_sof, pix_eol}, 0);
      rst_n = 1'b1;
      @(negedge pclk);
      check(pix_data == 16'h0 && pix_col == '0 && pix_row == '0 && !pix_valid,
            "R1 outputs after reset", pix_data, 0);
      repeat (2) @(negedge pclk);
      send_frame(9, 4, 1'b0, 1'b0);
      check(got_n == 0, "R9 no pixels from partial frame", got_n, 0);
      // clean frames; line lengths sweep odd and even, one byte up (R3, R8)
      for (int f = 0; f < 6; f++) send_frame(f, (f * 3) / 2 + 1, 1'b1, 1'b1);
      check(exp_n > 40, "R2 enough pixels exercised", exp_n, 41);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge pclk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule